// File: doc/BRIEF.md
# Bus Error Address Capture Unit

This block sits beside a 32-bit bus arbiter and records where the first failing bus tenure went. Three error pulses can arm a capture: an address-phase time-out, a data-phase time-out, and a transfer error acknowledge raised by some other agent. When one of them fires while the unit is unlocked, the tenure address and its control signals (transfer type, size, burst) are stored and the unit locks. Later errors then leave the stored values alone until software re-arms the unit.

Software uses a small register port with a write strobe, a two-bit register select, write data and a registered read-back. Four registers sit behind it: the captured address, the captured control signals, a write-1-to-clear status register with nine event bits, and a matching interrupt enable register. The single interrupt output is high whenever an enabled status bit is set. Re-arming never erases the stored values, so the last captured address stays readable until the next capture replaces it.

Top module: `buserr_capture`

## Requirements
- R1: When `evt_i[0]` (address time-out), `evt_i[1]` (data time-out) or `tea_i` is high at a clock edge and the unit is unlocked, `ten_addr` and `ten_ctrl` are stored in the address capture register (select 0) and the control capture register (select 1), and the unit locks.
- R2: While locked, further error pulses do not change either capture register.
- R3: A write of any data with select 0 or select 1 unlocks the unit and does not change the contents of either capture register.
- R4: A status write (select 2) with data bit 0 or data bit 1 set unlocks the unit; a status write with both of those bits clear does not unlock it.
- R5: After an unlock, both capture registers keep their old values until the next capture.
- R6: If an unlock write and a capturing error pulse fall in the same cycle, the unlock applies first and the pulse captures new values and locks again.
- R7: After reset every register reads zero, the unit is unlocked and `irq_o` is low.
- R8: Status bit n (bits 0..8, LSB numbering: 0 address time-out, 1 data time-out, 2 bus activity time-out, 3 burst/size mismatch, 4 external control word access, 5 reserved transfer type, 6 address-only transfer, 7 several masters at top priority, 8 slave error acknowledge) is set by `evt_i[n]` and cleared by writing 1 to it at select 2; an event in the same cycle as the clear wins. Bits 9..31 read zero.
- R9: The enable register (select 3) stores data bits 0..8 on a write; bits 9..31 ignore writes and read zero.
- R10: `irq_o` equals the OR of (status AND enable), and it reflects a status or enable change in the same cycle that the register changes.
- R11: `reg_rdata` is registered: after each clock edge it holds the register chosen by `reg_sel` before that edge, as the register stood before that edge; the control capture is zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 address capture, 1 control capture, 2 status, 3 enable |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data of the selected register |
| evt_i | input | 9 | Per-tenure event pulses, one per status bit |
| tea_i | input | 1 | Transfer error acknowledge from another source |
| ten_addr | input | 32 | Address of the current tenure |
| ten_ctrl | input | 8 | Control signals of the current tenure |
| irq_o | output | 1 | Interrupt request |

## Verification
The capture path is tried with each of the three arming pulses on its own, with error pulses arriving while locked, and with each re-arm route (write to either capture register, status write touching bit 0 or bit 1, and a status write touching only other bits) so that a missing or extra unlock shows as a wrong address. A same-cycle re-arm plus error separates the two possible priorities. Long random traffic with mixed event vectors and writes then tells apart set-versus-clear priority in the status bits, masking of reserved bits and the same-cycle interrupt timing.

// File: rtl/bec_pkg.sv
package bec_pkg;
  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_STAT = 2'd2,
    SEL_EN   = 2'd3
  } bec_sel_e;

  localparam int NEVT   = 9;
  localparam int EV_ATO = 0;
  localparam int EV_DTO = 1;
endpackage

// File: rtl/bec_capture.sv
module bec_capture #(
  parameter int AW = 32,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          unlock_i,
  input  logic          trig_i,
  input  logic [AW-1:0] addr_i,
  input  logic [CW-1:0] ctrl_i,
  output logic [AW-1:0] addr_o,
  output logic [CW-1:0] ctrl_o,
  output logic          locked_o
);
  logic [AW-1:0] addr_q;
  logic [CW-1:0] ctrl_q;
  logic          locked_q;
  logic          lock_eff;
  logic          load;

  // unlock is applied before the new error is considered
  assign lock_eff = locked_q & ~unlock_i;
  assign load     = trig_i & ~lock_eff;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q   <= '0;
      ctrl_q   <= '0;
      locked_q <= 1'b0;
    end else begin
      locked_q <= lock_eff | trig_i;
      if (load) begin
        addr_q <= addr_i;
        ctrl_q <= ctrl_i;
      end
    end
  end

  assign addr_o   = addr_q;
  assign ctrl_o   = ctrl_q;
  assign locked_o = locked_q;

  AST_CAPTURE_LOAD: assert property (@(posedge clk) disable iff (rst)
    trig_i && !locked_q |=> addr_q == $past(addr_i) && ctrl_q == $past(ctrl_i) && locked_q); // R1
  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (rst)
    locked_q && !unlock_i |=> $stable(addr_q) && $stable(ctrl_q) && locked_q); // R2
  AST_UNLOCK_KEEP: assert property (@(posedge clk) disable iff (rst)
    unlock_i && !trig_i |=> !locked_q && $stable(addr_q) && $stable(ctrl_q)); // R5
  AST_SAME_CYCLE: assert property (@(posedge clk) disable iff (rst)
    unlock_i && trig_i |=> locked_q && addr_q == $past(addr_i)); // R6
endmodule

// File: rtl/bec_status.sv
module bec_status #(
  parameter int NE = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NE-1:0] evt_i,
  input  logic [NE-1:0] clr_i,
  input  logic          en_wr_i,
  input  logic [NE-1:0] en_wdata_i,
  output logic [NE-1:0] stat_o,
  output logic [NE-1:0] en_o,
  output logic          irq_o
);
  logic [NE-1:0] stat_q, stat_d;
  logic [NE-1:0] en_q, en_d;
  logic          irq_q;

  // per-bit: event sets, write-1 clears, event wins
  for (genvar b = 0; b < NE; b++) begin : g_bit
    always_comb begin
      stat_d[b] = evt_i[b] | (stat_q[b] & ~clr_i[b]);
      en_d[b]   = en_wr_i ? en_wdata_i[b] : en_q[b];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      en_q   <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      en_q   <= en_d;
      irq_q  <= |(stat_d & en_d);
    end
  end

  assign stat_o = stat_q;
  assign en_o   = en_q;
  assign irq_o  = irq_q;

  AST_EVT_SET: assert property (@(posedge clk) disable iff (rst)
    |evt_i |=> (stat_q & $past(evt_i)) == $past(evt_i)); // R8
  AST_W1C: assert property (@(posedge clk) disable iff (rst)
    |(clr_i & ~evt_i) |=> (stat_q & $past(clr_i & ~evt_i)) == '0); // R8
  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (rst)
    irq_q == |(stat_q & en_q)); // R10
endmodule

// File: rtl/buserr_capture.sv
module buserr_capture
  import bec_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic [1:0]    reg_sel,
  input  logic [AW-1:0] reg_wdata,
  output logic [AW-1:0] reg_rdata,
  input  logic [NEVT-1:0] evt_i,
  input  logic          tea_i,
  input  logic [AW-1:0] ten_addr,
  input  logic [CW-1:0] ten_ctrl,
  output logic          irq_o
);
  bec_sel_e        sel;
  logic            wr_cap, wr_stat, wr_en;
  logic            unlock, trig;
  logic [NEVT-1:0] clr_mask;
  logic [AW-1:0]   cap_addr;
  logic [CW-1:0]   cap_ctrl;
  logic            locked;
  logic [NEVT-1:0] stat, en;
  logic [AW-1:0]   rd_d, rd_q;

  assign sel     = bec_sel_e'(reg_sel);
  assign wr_cap  = reg_wr & (sel == SEL_ADDR || sel == SEL_CTRL);
  assign wr_stat = reg_wr & (sel == SEL_STAT);
  assign wr_en   = reg_wr & (sel == SEL_EN);

  assign unlock   = wr_cap | (wr_stat & (reg_wdata[EV_ATO] | reg_wdata[EV_DTO]));
  assign trig     = evt_i[EV_ATO] | evt_i[EV_DTO] | tea_i;
  assign clr_mask = wr_stat ? reg_wdata[NEVT-1:0] : '0;

  bec_capture #(.AW(AW), .CW(CW)) cap_i (
    .clk      (clk),
    .rst      (rst),
    .unlock_i (unlock),
    .trig_i   (trig),
    .addr_i   (ten_addr),
    .ctrl_i   (ten_ctrl),
    .addr_o   (cap_addr),
    .ctrl_o   (cap_ctrl),
    .locked_o (locked)
  );

  bec_status #(.NE(NEVT)) stat_i (
    .clk        (clk),
    .rst        (rst),
    .evt_i      (evt_i),
    .clr_i      (clr_mask),
    .en_wr_i    (wr_en),
    .en_wdata_i (reg_wdata[NEVT-1:0]),
    .stat_o     (stat),
    .en_o       (en),
    .irq_o      (irq_o)
  );

  always_comb begin
    rd_d = '0;
    unique case (sel)
      SEL_ADDR: rd_d = cap_addr;
      SEL_CTRL: rd_d[CW-1:0] = cap_ctrl;
      SEL_STAT: rd_d[NEVT-1:0] = stat;
      SEL_EN:   rd_d[NEVT-1:0] = en;
      default:  rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_d;
  end

  assign reg_rdata = rd_q;

  AST_STATUS_UNLOCK: assert property (@(posedge clk) disable iff (rst)
    wr_stat && (reg_wdata[EV_ATO] || reg_wdata[EV_DTO]) && !trig |=> !locked); // R4
  AST_STATUS_NO_UNLOCK: assert property (@(posedge clk) disable iff (rst)
    wr_stat && !reg_wdata[EV_ATO] && !reg_wdata[EV_DTO] && locked |=> locked); // R4
  AST_CAP_WRITE_UNLOCK: assert property (@(posedge clk) disable iff (rst)
    wr_cap && !trig |=> !locked && $stable(cap_addr)); // R3
  AST_EN_RESERVED: assert property (@(posedge clk) disable iff (rst)
    sel == SEL_EN |=> reg_rdata[AW-1:NEVT] == '0); // R9
  AST_RD_ADDR: assert property (@(posedge clk) disable iff (rst)
    sel == SEL_ADDR |=> reg_rdata == $past(cap_addr)); // R11
endmodule

// File: tb/buserr_capture_tb_top.sv
`timescale 1ns/1ps
module buserr_capture_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [8:0]  evt_i = '0;
  logic        tea_i = 1'b0;
  logic [31:0] ten_addr = '0;
  logic [7:0]  ten_ctrl = '0;
  logic        irq_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference state
  logic [31:0] m_addr, m_rd;
  logic [7:0]  m_ctrl;
  logic [8:0]  m_stat, m_en;
  bit          m_lock, m_irq;

  always #10 clk = ~clk;

  buserr_capture dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_i(evt_i),
    .tea_i(tea_i), .ten_addr(ten_addr), .ten_ctrl(ten_ctrl), .irq_o(irq_o)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_addr = '0; m_ctrl = '0; m_stat = '0; m_en = '0;
    m_lock = 0; m_irq = 0; m_rd = '0;
  endtask

  task automatic model_step();
    bit unl, trg;
    logic [8:0] clr;
    case (reg_sel)
      2'd0: m_rd = m_addr;
      2'd1: m_rd = {24'd0, m_ctrl};
      2'd2: m_rd = {23'd0, m_stat};
      default: m_rd = {23'd0, m_en};
    endcase
    unl = reg_wr && (reg_sel < 2 || (reg_sel == 2 && (reg_wdata[0] || reg_wdata[1])));
    if (unl) m_lock = 0;
    trg = evt_i[0] || evt_i[1] || tea_i;
    if (trg && !m_lock) begin
      m_addr = ten_addr;
      m_ctrl = ten_ctrl;
      m_lock = 1;
    end
    clr = (reg_wr && reg_sel == 2) ? reg_wdata[8:0] : '0;
    m_stat = (m_stat & ~clr) | evt_i;
    if (reg_wr && reg_sel == 3) m_en = reg_wdata[8:0];
    m_irq = |(m_stat & m_en);
  endtask

  // one cycle: drive at negedge, step model at posedge, compare at next negedge
  task automatic cyc(string tag, bit wr, logic [1:0] sel, logic [31:0] wd,
                     logic [8:0] ev, bit tea, logic [31:0] a, logic [7:0] c);
    reg_wr = wr; reg_sel = sel; reg_wdata = wd;
    evt_i = ev; tea_i = tea; ten_addr = a; ten_ctrl = c;
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk({tag, " rdata"}, reg_rdata, m_rd);
    chk({tag, " R10 irq"}, {31'd0, irq_o}, {31'd0, m_irq});
  endtask

  task automatic rd(string tag, logic [1:0] sel, logic [31:0] exp);
    cyc(tag, 0, sel, '0, '0, 0, 32'hDEAD_0000, 8'h00);
    chk({tag, " hand"}, reg_rdata, exp);
  endtask

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R7 reset rdata", reg_rdata, 32'd0);
    chk("R7 reset irq", {31'd0, irq_o}, 32'd0);
    rd("R7 addr", 2'd0, 32'd0);
    rd("R7 stat", 2'd2, 32'd0);
    rd("R7 en", 2'd3, 32'd0);

    cyc("R1 ato", 0, 2'd2, '0, 9'h001, 0, 32'hA000_0001, 8'h11);
    rd("R1 addr", 2'd0, 32'hA000_0001);
    rd("R1 ctrl", 2'd1, 32'h0000_0011);
    cyc("R2 dto locked", 0, 2'd2, '0, 9'h002, 0, 32'hB000_0002, 8'h22);
    cyc("R2 tea locked", 0, 2'd2, '0, 9'h000, 1, 32'hB000_0003, 8'h23);
    rd("R2 addr", 2'd0, 32'hA000_0001);
    cyc("R4 no unlock", 1, 2'd2, 32'h0000_0100, '0, 0, 32'h0, 8'h0);
    cyc("R4 tea still locked", 0, 2'd3, '0, '0, 1, 32'hC000_0004, 8'h33);
    rd("R4 addr kept", 2'd0, 32'hA000_0001);
    cyc("R3 wr ctrl reg", 1, 2'd1, 32'hFFFF_FFFF, '0, 0, 32'h0, 8'h0);
    rd("R5 addr after unlock", 2'd0, 32'hA000_0001);
    rd("R3 ctrl unchanged", 2'd1, 32'h0000_0011);
    cyc("R1 tea", 0, 2'd3, '0, '0, 1, 32'hD000_0005, 8'h44);
    rd("R1 tea addr", 2'd0, 32'hD000_0005);
    cyc("R4 unlock bit0", 1, 2'd2, 32'h0000_0001, '0, 0, 32'h0, 8'h0);
    cyc("R1 dto", 0, 2'd3, '0, 9'h002, 0, 32'hE000_0006, 8'h55);
    rd("R4 new addr", 2'd0, 32'hE000_0006);
    cyc("R6 same cycle", 1, 2'd0, 32'h0, 9'h001, 0, 32'hF000_0007, 8'h66);
    rd("R6 addr", 2'd0, 32'hF000_0007);
    cyc("R6 relocked", 0, 2'd3, '0, '0, 1, 32'h1234_5678, 8'h77);
    rd("R6 addr held", 2'd0, 32'hF000_0007);
    cyc("R9 en write", 1, 2'd3, 32'hFFFF_FE04, '0, 0, 32'h0, 8'h0);
    rd("R9 en read", 2'd3, 32'h0000_0004);
    cyc("R8 R10 evt2", 0, 2'd2, '0, 9'h004, 0, 32'h0, 8'h0);
    chk("R10 irq set", {31'd0, irq_o}, 32'd1);
    cyc("R8 clr vs evt", 1, 2'd2, 32'h0000_0004, 9'h004, 0, 32'h0, 8'h0);
    chk("R8 event wins", {31'd0, irq_o}, 32'd1);
    cyc("R8 clr", 1, 2'd2, 32'hFFFF_FFFC, '0, 0, 32'h0, 8'h0);
    chk("R10 irq clear", {31'd0, irq_o}, 32'd0);

    for (int i = 0; i < 4000; i++) begin
      logic [8:0] ev;
      ev = '0;
      for (int b = 0; b < 9; b++) if ($urandom_range(0, 9) == 0) ev[b] = 1'b1;
      cyc("R8 R11 random", $urandom_range(0, 3) == 0, 2'($urandom_range(0, 3)),
          $urandom, ev, $urandom_range(0, 11) == 0, $urandom, 8'($urandom));
    end

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++;
      total++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule